// File: doc/BRIEF.md
# UART Register Interface

This block sits between a byte-wide CPU bus and a UART transmit/receive core. A single register-select line and a read/write line pick one of four registers. A control register can only be written, and so can the transmit data register. A status register can only be read, and so can the receive data register. The block keeps every status flag. It drives an active-low interrupt line and a request-to-send level. It takes a carrier-loss input and a clear-to-send blocking input. It sends the character-format and clock-ratio fields to the serial core. It exchanges characters with that core through a one-cycle load pulse on the transmit side and a one-cycle valid strobe on the receive side.

The interface keeps the serial core idle after power-up. Software must first write the master-reset ratio code. It must then write any other ratio code. Only after these two writes does the core-enable output go high. A later master-reset write makes the interface idle again and clears its flags.

Top module: `uart_regif`

## Requirements
- R1: After reset the outputs are `core_en_o`=0, `irq_n_o`=1, `rts_n_o`=0 and `brk_o`=0, and a status read returns 0x02. Status bit positions: 0 receive full, 1 transmit empty, 2 carrier lost, 3 clear-to-send input, 4 framing error, 5 overrun, 6 parity error, 7 interrupt.
- R2: `core_en_o` goes to 1 only on a control write with bits 1:0 not equal to 11, and only if an earlier write had bits 1:0 equal to 11. `ratio_o` follows control bits 1:0 and `fmt_o` follows control bits 4:2. `rs_i`=0 selects control/status. `rs_i`=1 selects the data registers. `rd_i`=1 selects a read.
- R3: A control write with bits 1:0 equal to 11 drops `core_en_o`, clears every receive flag and sets transmit-empty. While the core is disabled, receive strobes are ignored.
- R4: A transmit data write clears status bit 1. When the core is enabled, clear-to-send is low and break is off, `tx_ready_i` high produces one `tx_load_o` pulse that carries the written byte, and status bit 1 is then set again.
- R5: While `cts_block_i` is high, status bit 1 reads 0, status bit 3 reads 1, and no load is issued.
- R6: An accepted receive strobe sets status bit 0. A data read returns the byte and clears bit 0.
- R7: If a character arrives while bit 0 is still set and no data read happens in the same cycle, the held byte is kept and bit 5 is set. A data read clears bit 5. If a data read and an arrival fall in the same cycle, the read returns the old byte, the new byte is stored, and no overrun is flagged.
- R8: While `carrier_lost_i` is high, bit 2 is set, bit 0 is cleared and arrivals are ignored. Bit 2 stays set after the carrier returns. A data read on its own does not clear bit 2. A status read followed by a data read clears it.
- R9: Control bits 6:5 = 10 drive `rts_n_o`=1. Code 11 drives `brk_o`=1 and holds off transmit loads. Every other code gives `rts_n_o`=0 and `brk_o`=0.
- R10: Status bit 7 = (control bit 7 and (bit 0 or bit 5 or bit 2)) or (control bits 6:5 = 01 and transmit-empty and clear-to-send low). `irq_n_o` is its inverse, one cycle later.
- R11: Each accepted character writes both bit 6 and bit 4. A data read clears bit 6 and leaves bit 4 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Bus access strobe, one cycle per access |
| rs_i | input | 1 | Register select: 0 control/status, 1 data |
| rd_i | input | 1 | 1 read, 0 write |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after the access |
| carrier_lost_i | input | 1 | High when the carrier is absent |
| cts_block_i | input | 1 | High when the far end is not clear to receive |
| rts_n_o | output | 1 | Request-to-send level |
| irq_n_o | output | 1 | Active-low interrupt request |
| ratio_o | output | 2 | Clock-to-data ratio code to the core |
| fmt_o | output | 3 | Word length / parity / stop-bit code to the core |
| core_en_o | output | 1 | Core enable after the reset-then-ratio write sequence |
| brk_o | output | 1 | Hold the transmit line low |
| tx_load_o | output | 1 | One-cycle load pulse to the transmitter |
| tx_data_o | output | DW | Byte for the transmitter |
| tx_ready_i | input | 1 | Transmitter can accept a byte |
| rx_valid_i | input | 1 | Last bit of a character has arrived |
| rx_data_i | input | DW | Received byte |
| rx_par_err_i | input | 1 | Parity error of the arriving character |
| rx_frm_err_i | input | 1 | Missing stop bit of the arriving character |

## Verification
Two receive-side events can fall in the same clock cycle: a CPU read of the receive data register and the arrival of a new character from the core. The bench drives the data-register read and the receive strobe at the same negative edge. It expects the read data to hold the old byte, the overrun bit to stay clear, and the following data read to return the new byte. The same-cycle collision between a transmit data write and a pending load is handled by letting the write win. The one-cycle load pulse and the held-off loads are checked by watching `tx_load_o` over a window of cycles.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int CTRL_W = 8;
  localparam int STAT_W = 8;

  localparam int ST_RXFULL = 0;
  localparam int ST_TXEMPTY = 1;
  localparam int ST_CARRIER = 2;
  localparam int ST_CTS = 3;
  localparam int ST_FRAME = 4;
  localparam int ST_OVERRUN = 5;
  localparam int ST_PARITY = 6;
  localparam int ST_IRQ = 7;

  localparam logic [1:0] RATIO_MRESET = 2'b11;

  typedef enum logic [1:0] {
    TXM_QUIET  = 2'b00,
    TXM_IRQ    = 2'b01,
    TXM_RTS_HI = 2'b10,
    TXM_BREAK  = 2'b11
  } txmode_e;

  typedef struct packed {
    logic       rx_irq_en;
    txmode_e    txmode;
    logic [2:0] fmt;
    logic [1:0] ratio;
  } ctrl_t;
endpackage

// File: rtl/uart_regif_ctrl.sv
module uart_regif_ctrl
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl_o,
  output logic              core_en_o,
  output logic              mreset_o
);
  logic seen_mreset_q;

  assign mreset_o = wr_en && (wdata[1:0] == RATIO_MRESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o        <= '0;
      seen_mreset_q <= 1'b0;
      core_en_o     <= 1'b0;
    end else if (wr_en) begin
      ctrl_o <= ctrl_t'(wdata);
      if (wdata[1:0] == RATIO_MRESET) begin
        seen_mreset_q <= 1'b1;
        core_en_o     <= 1'b0;
      end else if (seen_mreset_q) begin
        core_en_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_regif_rx.sv
module uart_regif_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          carrier_lost,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_pe,
  input  logic          rx_fe,
  input  logic          rd_data,
  input  logic          rd_stat,
  output logic [DW-1:0] hold_o,
  output logic          full_o,
  output logic          ovr_o,
  output logic          pe_o,
  output logic          fe_o,
  output logic          dcd_o
);
  logic accept;
  logic dcd_arm_q;

  assign accept = rx_valid && en && !carrier_lost;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hold_o    <= '0;
      full_o    <= 1'b0;
      ovr_o     <= 1'b0;
      pe_o      <= 1'b0;
      fe_o      <= 1'b0;
      dcd_o     <= 1'b0;
      dcd_arm_q <= 1'b0;
    end else begin
      if (rd_data) begin
        full_o <= 1'b0;
        pe_o   <= 1'b0;
        ovr_o  <= 1'b0;
      end
      if (accept) begin
        if (full_o && !rd_data) begin
          ovr_o <= 1'b1;
        end else begin
          hold_o <= rx_data;
          full_o <= 1'b1;
          pe_o   <= rx_pe;
          fe_o   <= rx_fe;
        end
      end
      if (carrier_lost) full_o <= 1'b0;

      if (carrier_lost) begin
        dcd_o <= 1'b1;
      end else if (rd_data && dcd_arm_q) begin
        dcd_o <= 1'b0;
      end
      if (rd_stat && dcd_o) begin
        dcd_arm_q <= 1'b1;
      end else if (rd_data) begin
        dcd_arm_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_regif_tx.sv
module uart_regif_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          wr_data,
  input  logic [DW-1:0] wdata,
  input  logic          tx_ready,
  input  logic          cts_block,
  input  logic          brk,
  output logic          empty_o,
  output logic          load_o,
  output logic [DW-1:0] data_o
);
  logic can_load;

  assign can_load = !empty_o && en && tx_ready && !cts_block && !brk;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      empty_o <= 1'b1;
      load_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      load_o <= 1'b0;
      if (wr_data) begin
        data_o  <= wdata;
        empty_o <= 1'b0;
      end else if (can_load) begin
        load_o  <= 1'b1;
        empty_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_i,
  input  logic          rs_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          carrier_lost_i,
  input  logic          cts_block_i,
  output logic          rts_n_o,
  output logic          irq_n_o,
  output logic [1:0]    ratio_o,
  output logic [2:0]    fmt_o,
  output logic          core_en_o,
  output logic          brk_o,
  output logic          tx_load_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_par_err_i,
  input  logic          rx_frm_err_i
);
  logic wr_ctl, wr_tx, rd_st, rd_rx;
  ctrl_t ctrl_q;
  logic mreset;
  logic [DW-1:0] rx_hold;
  logic rx_full, rx_ovr, rx_pe, rx_fe, rx_dcd, tx_empty;
  logic irq_w;
  logic [STAT_W-1:0] stat_w;

  assign wr_ctl = cs_i && !rd_i && !rs_i;
  assign wr_tx  = cs_i && !rd_i && rs_i;
  assign rd_st  = cs_i && rd_i && !rs_i;
  assign rd_rx  = cs_i && rd_i && rs_i;

  uart_regif_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_ctl), .wdata(wdata_i[CTRL_W-1:0]),
    .ctrl_o(ctrl_q), .core_en_o(core_en_o), .mreset_o(mreset)
  );

  uart_regif_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .clr(mreset), .en(core_en_o),
    .carrier_lost(carrier_lost_i), .rx_valid(rx_valid_i), .rx_data(rx_data_i),
    .rx_pe(rx_par_err_i), .rx_fe(rx_frm_err_i), .rd_data(rd_rx), .rd_stat(rd_st),
    .hold_o(rx_hold), .full_o(rx_full), .ovr_o(rx_ovr), .pe_o(rx_pe),
    .fe_o(rx_fe), .dcd_o(rx_dcd)
  );

  uart_regif_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .clr(mreset), .en(core_en_o), .wr_data(wr_tx),
    .wdata(wdata_i), .tx_ready(tx_ready_i), .cts_block(cts_block_i),
    .brk(brk_o), .empty_o(tx_empty), .load_o(tx_load_o), .data_o(tx_data_o)
  );

  assign ratio_o = ctrl_q.ratio;
  assign fmt_o   = ctrl_q.fmt;
  assign rts_n_o = (ctrl_q.txmode == TXM_RTS_HI);
  assign brk_o   = (ctrl_q.txmode == TXM_BREAK);

  assign irq_w = (ctrl_q.rx_irq_en && (rx_full || rx_ovr || rx_dcd)) ||
                 ((ctrl_q.txmode == TXM_IRQ) && tx_empty && !cts_block_i);

  always_comb begin
    stat_w              = '0;
    stat_w[ST_RXFULL]   = rx_full;
    stat_w[ST_TXEMPTY]  = tx_empty && !cts_block_i;
    stat_w[ST_CARRIER]  = rx_dcd;
    stat_w[ST_CTS]      = cts_block_i;
    stat_w[ST_FRAME]    = rx_fe;
    stat_w[ST_OVERRUN]  = rx_ovr;
    stat_w[ST_PARITY]   = rx_pe;
    stat_w[ST_IRQ]      = irq_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_n_o <= 1'b1;
    end else begin
      irq_n_o <= !irq_w;
      if (rd_st) rdata_o <= DW'(stat_w);
      else if (rd_rx) rdata_o <= rx_hold;
    end
  end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk (
  input logic       clk,
  input logic       rst,
  input logic       carrier_lost_i,
  input logic       cts_block_i,
  input logic       core_en_o,
  input logic [1:0] ratio_o,
  input logic       brk_o,
  input logic       tx_load_o,
  input logic       irq_n_o,
  input logic [7:0] stat_w
);
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tx_load_o |=> !tx_load_o); // R4
  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (rst)
    tx_load_o |-> $past(core_en_o && !brk_o && !cts_block_i)); // R5
  AST_ARM_AFTER_MRESET: assert property (@(posedge clk) disable iff (rst)
    $rose(core_en_o) |-> ($past(ratio_o) == 2'b11)); // R2
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_w[5]) |-> $past(stat_w[0])); // R7
  AST_CARRIER_DROPS_FULL: assert property (@(posedge clk) disable iff (rst)
    carrier_lost_i |=> (!stat_w[0] && stat_w[2])); // R8
  AST_IRQ_PIN: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == !$past(stat_w[7])); // R10
endmodule

bind uart_regif uart_regif_chk u_chk (
  .clk(clk), .rst(rst), .carrier_lost_i(carrier_lost_i),
  .cts_block_i(cts_block_i), .core_en_o(core_en_o), .ratio_o(ratio_o),
  .brk_o(brk_o), .tx_load_o(tx_load_o), .irq_n_o(irq_n_o), .stat_w(stat_w)
);

// File: tb/uart_regif_tb.sv
module uart_regif_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, rs = 0, rd = 0;
  logic [7:0] wdata = '0, rdata;
  logic carrier_lost = 0, cts_block = 0, rts_n, irq_n;
  logic [1:0] ratio;
  logic [2:0] fmt;
  logic core_en, brk, tx_load, tx_ready = 0;
  logic [7:0] tx_data;
  logic rx_valid = 0, rx_pe = 0, rx_fe = 0;
  logic [7:0] rx_data = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] got;
  bit seen;
  logic [7:0] ld;

  always #5 clk = ~clk;

  uart_regif #(.DW(8)) u_dut (
    .clk(clk), .rst(rst), .cs_i(cs), .rs_i(rs), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .carrier_lost_i(carrier_lost), .cts_block_i(cts_block),
    .rts_n_o(rts_n), .irq_n_o(irq_n), .ratio_o(ratio), .fmt_o(fmt),
    .core_en_o(core_en), .brk_o(brk), .tx_load_o(tx_load), .tx_data_o(tx_data),
    .tx_ready_i(tx_ready), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_par_err_i(rx_pe), .rx_frm_err_i(rx_fe)
  );

  typedef struct packed {
    logic [7:0] c;
    logic [1:0] r;
    logic [2:0] f;
    logic       rts;
    logic       brk;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h15, 2'b01, 3'b101, 1'b0, 1'b0},
    '{8'h4A, 2'b10, 3'b010, 1'b1, 1'b0},
    '{8'h60, 2'b00, 3'b000, 1'b0, 1'b1},
    '{8'h3D, 2'b01, 3'b111, 1'b0, 1'b0},
    '{8'hA6, 2'b10, 3'b001, 1'b0, 1'b0},
    '{8'hD0, 2'b00, 3'b100, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cs = 1; rs = sel; rd = 0; wdata = d;
    @(negedge clk); cs = 0;
  endtask

  task automatic rdreg(input logic sel, output logic [7:0] q);
    @(negedge clk); cs = 1; rs = sel; rd = 1;
    @(negedge clk); cs = 0; rd = 0; q = rdata;
  endtask

  task automatic rxchar(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_pe = pe; rx_fe = fe;
    @(negedge clk); rx_valid = 0; rx_pe = 0; rx_fe = 0;
  endtask

  task automatic watch_load(input int n, output bit s, output logic [7:0] d);
    s = 0; d = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_load) begin s = 1; d = tx_data; end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 core_en", core_en, 0);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 rts_n/brk", {rts_n, brk}, 0);
    rdreg(0, got); chk("R1 status", got, 8'h02);

    // R2 arming sequence
    wr(0, 8'h15); chk("R2 no arm without mreset", core_en, 0);
    wr(0, 8'h03); chk("R2 mreset ratio", {core_en, ratio}, 3'b011);
    wr(0, 8'h15); chk("R2 armed", core_en, 1);

    // R2/R9 control field table
    for (int i = 0; i < NV; i++) begin
      wr(0, VECS[i].c);
      chk("R2 R9 ctrl fields", {ratio, fmt, rts_n, brk},
          {VECS[i].r, VECS[i].f, VECS[i].rts, VECS[i].brk});
    end
    wr(0, 8'h15);

    // R4 transmit path
    wr(1, 8'hA5);
    rdreg(0, got); chk("R4 tx empty cleared", got, 8'h00);
    tx_ready = 1;
    watch_load(3, seen, ld); tx_ready = 0;
    chk("R4 load byte", {seen, ld}, {1'b1, 8'hA5});
    rdreg(0, got); chk("R4 tx empty again", got, 8'h02);

    // R5 clear-to-send blocking
    cts_block = 1;
    rdreg(0, got); chk("R5 status under cts", got, 8'h08);
    wr(1, 8'h3C); tx_ready = 1;
    watch_load(3, seen, ld); chk("R5 no load", seen, 0);
    cts_block = 0;
    watch_load(3, seen, ld); tx_ready = 0;
    chk("R5 load after release", {seen, ld}, {1'b1, 8'h3C});

    // R6 receive
    rxchar(8'h5A, 0, 0);
    rdreg(0, got); chk("R6 rx full", got, 8'h03);
    rdreg(1, got); chk("R6 rx byte", got, 8'h5A);
    rdreg(0, got); chk("R6 rx cleared", got, 8'h02);

    // R11 parity / framing
    rxchar(8'h11, 1, 1);
    rdreg(0, got); chk("R11 pe fe set", got, 8'h53);
    rdreg(1, got); chk("R11 byte", got, 8'h11);
    rdreg(0, got); chk("R11 pe cleared fe kept", got, 8'h12);
    rxchar(8'h22, 0, 0);
    rdreg(0, got); chk("R11 fe overwritten", got, 8'h03);
    rdreg(1, got);

    // R7 overrun
    rxchar(8'h33, 0, 0);
    rxchar(8'h44, 0, 0);
    rdreg(0, got); chk("R7 overrun set", got, 8'h23);
    rdreg(1, got); chk("R7 old byte kept", got, 8'h33);
    rdreg(0, got); chk("R7 overrun cleared", got, 8'h02);
    rxchar(8'h55, 0, 0);
    @(negedge clk); cs = 1; rs = 1; rd = 1; rx_valid = 1; rx_data = 8'h66;
    @(negedge clk); cs = 0; rd = 0; rx_valid = 0; got = rdata;
    chk("R7 same-cycle read old", got, 8'h55);
    rdreg(0, got); chk("R7 same-cycle no overrun", got, 8'h03);
    rdreg(1, got); chk("R7 same-cycle new byte", got, 8'h66);

    // R8 carrier loss
    rxchar(8'h77, 0, 0);
    @(negedge clk); carrier_lost = 1;
    @(negedge clk);
    rxchar(8'h88, 0, 0);
    carrier_lost = 0;
    rdreg(1, got);
    rdreg(0, got); chk("R8 latched after data read alone", got, 8'h06);
    rdreg(1, got);
    rdreg(0, got); chk("R8 cleared by status+data read", got, 8'h02);

    // R10 interrupts
    wr(0, 8'h95); chk("R10 idle irq", irq_n, 1);
    rxchar(8'h99, 0, 0);
    @(negedge clk); chk("R10 rx irq", irq_n, 0);
    rdreg(0, got); chk("R10 status bit7", got, 8'h83);
    rdreg(1, got);
    @(negedge clk); chk("R10 irq cleared by read", irq_n, 1);
    wr(0, 8'h35);
    @(negedge clk); chk("R10 tx irq", irq_n, 0);
    cts_block = 1;
    @(negedge clk); chk("R10 tx irq held off by cts", irq_n, 1);
    cts_block = 0;
    wr(1, 8'h0F);
    @(negedge clk); chk("R10 irq cleared by tx write", irq_n, 1);
    tx_ready = 1; watch_load(3, seen, ld); tx_ready = 0;
    wr(0, 8'h15);

    // R9 break
    wr(0, 8'h75); chk("R9 break on", {brk, rts_n}, 2'b10);
    wr(1, 8'hC3); tx_ready = 1;
    watch_load(3, seen, ld); chk("R9 no load in break", seen, 0);
    wr(0, 8'h15);
    watch_load(3, seen, ld); tx_ready = 0;
    chk("R9 load after break", {seen, ld}, {1'b1, 8'hC3});

    // R3 master reset
    rxchar(8'hAB, 0, 0);
    wr(1, 8'h5E);
    rdreg(0, got); chk("R3 before mreset", got, 8'h01);
    wr(0, 8'h03); chk("R3 core disabled", core_en, 0);
    rdreg(0, got); chk("R3 flags cleared", got, 8'h02);
    rxchar(8'hCD, 0, 0);
    rdreg(0, got); chk("R3 rx ignored while idle", got, 8'h02);
    wr(0, 8'h15); chk("R3 re-armed", core_en, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule